// File: doc/BRIEF.md
# SEC-DED Protected Memory Wrapper with Read-Modify-Write

This block places a single-port synchronous RAM behind a simple request/response port and guards every stored 32-bit chunk with seven check bits. The result is a 39-bit codeword that corrects any single flipped bit and detects any pair of flipped bits. A requester presents an address, a write flag, byte enables and write data under a valid/ready handshake. Each request produces one response pulse, which carries read data and two error flags.

A write that enables all four bytes is encoded and stored in a single cycle. A write with fewer byte enables first reads the stored codeword, corrects it and merges the enabled bytes. It then re-encodes the merged chunk and stores it. A read that finds a single-bit error returns corrected data, writes the corrected codeword back to the array and reads the location again before it responds. A double-bit error is reported as uncorrectable and nothing is written back. The requester sees these internal sequences only as extra latency, because the wrapper takes no new request until the current one has finished.

Two saturating counters record corrected and uncorrectable events, and an input clears both. A fault-injection input can flip chosen codeword bits as a write request stores its codeword, so that the error paths can be exercised.

Top module: `ecc_mem_rmw`

## Requirements
- R1: A write with req_be equal to 4'b1111 is stored directly. rsp_valid pulses in the first cycle after the accepting edge, with both flags low. A later clean read of that address responds two cycles after its accepting edge, with the written data and both flags low.
- R2: A write with at least one req_be bit low is a read-modify-write. req_be[i] selects req_wdata[8i+7:8i] to replace byte i, and the remaining bytes keep their stored, corrected value. The response comes two cycles after acceptance.
- R3: A read of a codeword with exactly one flipped bit returns the corrected data with rsp_corr high, and it responds four cycles after acceptance because of the scrub write and re-read. A partial write over such a codeword raises rsp_corr in its two-cycle response.
- R4: After a corrected read, the corrected codeword is in the array, so the next read of that address has both flags low.
- R5: A read of a codeword with two flipped bits raises rsp_uncorr two cycles after acceptance and writes nothing back, so a repeat read reports it again.
- R6: A partial write over a codeword with two flipped bits is aborted. It raises rsp_uncorr, and the stored codeword is left unchanged, so a following read still reports rsp_uncorr.
- R7: req_ready is high only when the wrapper is idle. It stays high in the cycle after a full write is accepted, and it is low in the cycle after a read or partial write is accepted.
- R8: cnt_corr and cnt_uncorr each add one per corrected or uncorrectable event and saturate at 2^CNT_W-1.
- R9: cnt_clr zeroes both counters on the next edge, and it takes precedence over an event that falls on the same edge.
- R10: Bit i of req_inject inverts bit i of the 39-bit codeword stored by a full write or a partial write. One set bit at any position, including the overall parity bit 0, produces a correctable error. Two set bits produce an uncorrectable one.
- R11: During and right after reset, req_ready is high, rsp_valid is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables for writes |
| req_addr | input | ADDR_W | Chunk address |
| req_wdata | input | 32 | Write data |
| req_inject | input | 39 | Codeword bits to invert when this write stores its codeword |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data; zero for writes |
| rsp_corr | output | 1 | A single-bit error was corrected |
| rsp_uncorr | output | 1 | A double-bit error was detected |
| cnt_clr | input | 1 | Clear both event counters |
| cnt_corr | output | CNT_W | Saturating count of corrected events |
| cnt_uncorr | output | CNT_W | Saturating count of uncorrectable events |

## Verification
The corrected-event counter can be asked to clear on the same edge at which a corrected error is detected. To provoke this, the bench raises cnt_clr in the cycle right after a read of a single-error codeword is accepted, which is the cycle in which the check stage decides. The counter must read zero afterwards, not one. Response latency is measured for every request against the expected one, two or four cycles, so a missing scrub or a re-read that never happens shows up as a timing failure as well as a data or flag failure.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

  localparam int DATA_W  = 32;
  localparam int PAR_W   = 6;
  localparam int CW_W    = DATA_W + PAR_W + 1;
  localparam int BYTES   = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REREAD,
    ST_RECHK
  } ctrl_st_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              single;
    logic              double;
  } dec_res_t;

  // Hamming positions 1..CW_W-1, check bits at powers of two, bit 0 = overall parity
  function automatic logic [CW_W-1:0] ecc_encode(logic [DATA_W-1:0] d);
    logic [CW_W-1:0] cw;
    logic            x;
    int              k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < PAR_W; i++) begin
      x = 1'b0;
      for (int p = 1; p < CW_W; p++) begin
        if (p[i]) x = x ^ cw[p];
      end
      cw[1 << i] = x;
    end
    cw[0] = ^cw[CW_W-1:1];
    return cw;
  endfunction

  function automatic dec_res_t ecc_decode(logic [CW_W-1:0] cw);
    dec_res_t         r;
    logic [CW_W-1:0]  fix;
    logic [PAR_W-1:0] syn;
    logic             ov;
    int               k;
    syn = '0;
    for (int p = 1; p < CW_W; p++) begin
      if (cw[p]) syn = syn ^ PAR_W'(p);
    end
    ov       = ^cw;
    fix      = cw;
    r.single = 1'b0;
    r.double = 1'b0;
    if (ov) begin
      if (int'(syn) < CW_W) begin
        fix[syn] = ~fix[syn];
        r.single = 1'b1;
      end else begin
        r.double = 1'b1;
      end
    end else if (syn != '0) begin
      r.double = 1'b1;
    end
    k = 0;
    r.data = '0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        r.data[k] = fix[p];
        k++;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_sram_array.sv
module ecc_sram_array #(
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 39
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/ecc_evt_counter.sv
module ecc_evt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (clr)                         count_n = '0;
    else if (inc && count != CNT_MAX) count_n = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [BYTES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW_W-1:0]   req_inject,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic [CW_W-1:0]   mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_corr,
  output logic              rsp_uncorr,
  output logic              evt_corr,
  output logic              evt_uncorr
);

  ctrl_st_e          state, state_n;
  logic              lat_ld;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_we;
  logic [BYTES-1:0]  lat_be;
  logic [DATA_W-1:0] lat_wdata;
  logic [CW_W-1:0]   lat_inj;

  logic              rv_n, rc_n, ru_n;
  logic [DATA_W-1:0] rd_n;

  dec_res_t          dec;
  logic [DATA_W-1:0] merged;

  always_comb begin
    dec = ecc_decode(mem_rdata);
    for (int b = 0; b < BYTES; b++) begin
      merged[8*b +: 8] = lat_be[b] ? lat_wdata[8*b +: 8] : dec.data[8*b +: 8];
    end
  end

  always_comb begin
    state_n    = state;
    lat_ld     = 1'b0;
    req_ready  = (state == ST_IDLE);
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = lat_addr;
    mem_wdata  = ecc_encode(merged) ^ lat_inj;
    rv_n       = 1'b0;
    rd_n       = '0;
    rc_n       = 1'b0;
    ru_n       = 1'b0;
    evt_corr   = 1'b0;
    evt_uncorr = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          lat_ld   = 1'b1;
          mem_en   = 1'b1;
          mem_addr = req_addr;
          if (req_we && (&req_be)) begin
            mem_we    = 1'b1;
            mem_wdata = ecc_encode(req_wdata) ^ req_inject;
            rv_n      = 1'b1;
          end else begin
            state_n = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (dec.double) begin
          rv_n       = 1'b1;
          ru_n       = 1'b1;
          rd_n       = lat_we ? '0 : dec.data;
          evt_uncorr = 1'b1;
          state_n    = ST_IDLE;
        end else if (lat_we) begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          rv_n     = 1'b1;
          rc_n     = dec.single;
          evt_corr = dec.single;
          state_n  = ST_IDLE;
        end else if (dec.single) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_wdata = ecc_encode(dec.data);
          evt_corr  = 1'b1;
          state_n   = ST_REREAD;
        end else begin
          rv_n    = 1'b1;
          rd_n    = dec.data;
          state_n = ST_IDLE;
        end
      end
      ST_REREAD: begin
        mem_en  = 1'b1;
        state_n = ST_RECHK;
      end
      ST_RECHK: begin
        rv_n    = 1'b1;
        rd_n    = dec.data;
        rc_n    = 1'b1;
        ru_n    = dec.double;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_corr   <= 1'b0;
      rsp_uncorr <= 1'b0;
    end else begin
      state      <= state_n;
      rsp_valid  <= rv_n;
      rsp_rdata  <= rd_n;
      rsp_corr   <= rc_n;
      rsp_uncorr <= ru_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_we    <= 1'b0;
      lat_be    <= '0;
      lat_wdata <= '0;
      lat_inj   <= '0;
    end else if (lat_ld) begin
      lat_addr  <= req_addr;
      lat_we    <= req_we;
      lat_be    <= req_be;
      lat_wdata <= req_wdata;
      lat_inj   <= req_inject;
    end
  end

endmodule

// File: rtl/ecc_mem_rmw.sv
module ecc_mem_rmw
  import ecc_mem_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [BYTES-1:0]  req_be,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CW_W-1:0]   req_inject,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_corr,
  output logic              rsp_uncorr,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_corr,
  output logic [CNT_W-1:0]  cnt_uncorr
);

  logic              mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [CW_W-1:0]   mem_wdata, mem_rdata;
  logic [1:0]        evt;

  ecc_rmw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_be     (req_be),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_inject (req_inject),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_corr   (rsp_corr),
    .rsp_uncorr (rsp_uncorr),
    .evt_corr   (evt[0]),
    .evt_uncorr (evt[1])
  );

  ecc_sram_array #(.ADDR_W(ADDR_W), .WIDTH(CW_W)) u_array (
    .clk   (clk),
    .en    (mem_en),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  logic [CNT_W-1:0] cnt_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    ecc_evt_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (evt[g]),
      .count (cnt_q[g])
    );
  end

  assign cnt_corr   = cnt_q[0];
  assign cnt_uncorr = cnt_q[1];

endmodule

// File: rtl/ecc_mem_rmw_chk.sv
module ecc_mem_rmw_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_we,
  input logic [3:0]       req_be,
  input logic             rsp_valid,
  input logic             rsp_corr,
  input logic             rsp_uncorr,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt_corr,
  input logic [CNT_W-1:0] cnt_uncorr
);

  a_r1_full_write_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we && (&req_be)) |=> (rsp_valid && req_ready));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_we && (&req_be))) |=> (!req_ready && !rsp_valid));

  // R3 / R5: error flags appear only on a response
  a_r3_flags_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_corr && !rsp_uncorr));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_corr == '0 && cnt_uncorr == '0));

  a_r8_corr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_corr == $past(cnt_corr) || cnt_corr == $past(cnt_corr) + CNT_W'(1)));

  a_r8_uncorr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_uncorr == $past(cnt_uncorr) || cnt_uncorr == $past(cnt_uncorr) + CNT_W'(1)));

endmodule

bind ecc_mem_rmw ecc_mem_rmw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_we     (req_we),
  .req_be     (req_be),
  .rsp_valid  (rsp_valid),
  .rsp_corr   (rsp_corr),
  .rsp_uncorr (rsp_uncorr),
  .cnt_clr    (cnt_clr),
  .cnt_corr   (cnt_corr),
  .cnt_uncorr (cnt_uncorr)
);

// File: tb/ecc_mem_rmw_bench.sv
module ecc_mem_rmw_bench;

  localparam int ADDR_W = 4;
  localparam int CNT_W  = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_we;
  logic [3:0]        req_be;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic [38:0]       req_inject;
  logic              cnt_clr;
  logic              req_ready, rsp_valid, rsp_corr, rsp_uncorr;
  logic [31:0]       rsp_rdata;
  logic [CNT_W-1:0]  cnt_corr, cnt_uncorr;

  always #2.5 clk = ~clk;

  ecc_mem_rmw #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ecc_mem_rmw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_inject(req_inject), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_corr(rsp_corr), .rsp_uncorr(rsp_uncorr), .cnt_clr(cnt_clr),
    .cnt_corr(cnt_corr), .cnt_uncorr(cnt_uncorr)
  );

  typedef struct {
    logic [31:0] data;
    bit          chk_data;
    bit          corr;
    bit          uncorr;
    int          start;
    int          lat;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_corr = 0;
  int    exp_uncorr = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: pops expected items as responses arrive
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc - e.start == e.lat, {e.tag, " latency"}, 64'(cyc - e.start), 64'(e.lat));
        chk(rsp_corr == e.corr, {e.tag, " corr flag"}, 64'(rsp_corr), 64'(e.corr));
        chk(rsp_uncorr == e.uncorr, {e.tag, " uncorr flag"}, 64'(rsp_uncorr), 64'(e.uncorr));
        if (e.chk_data) chk(rsp_rdata == e.data, {e.tag, " data"}, 64'(rsp_rdata), 64'(e.data));
      end
    end
  end

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  // driver: issue one request and push its expected response
  task automatic do_req(input bit we, input logic [3:0] be, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd, input logic [38:0] inj,
                        input logic [31:0] exp_d, input bit chk_d, input bit ec,
                        input bit eu, input int lat, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid  = 1'b1;
    req_we     = we;
    req_be     = be;
    req_addr   = a;
    req_wdata  = wd;
    req_inject = inj;
    e.data = exp_d; e.chk_data = chk_d; e.corr = ec; e.uncorr = eu;
    e.start = cyc; e.lat = lat; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid  = 1'b0;
    req_inject = '0;
    // R7: ready stays up after a full write, drops after anything else
    chk(req_ready == (we && (&be)), "R7 ready after accept", 64'(req_ready), 64'(we && (&be)));
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_cnt(input string tag);
    chk(int'(cnt_corr) == exp_corr, {tag, " cnt_corr"}, 64'(cnt_corr), 64'(exp_corr));
    chk(int'(cnt_uncorr) == exp_uncorr, {tag, " cnt_uncorr"}, 64'(cnt_uncorr), 64'(exp_uncorr));
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_be = '0;
    req_addr = '0; req_wdata = '0; req_inject = '0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R11 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cnt("R11");

    // R1: full write then clean read
    do_req(1, 4'hF, 4'd1, 32'hA5A5_1234, '0, '0, 0, 0, 0, 1, "R1 full write");
    do_req(0, 4'h0, 4'd1, '0, '0, 32'hA5A5_1234, 1, 0, 0, 2, "R1 clean read");
    // R2: partial merge, bytes 0 and 2 replaced
    do_req(1, 4'hF, 4'd2, 32'h1122_3344, '0, '0, 0, 0, 0, 1, "R2 base write");
    do_req(1, 4'b0101, 4'd2, 32'hAABB_CCDD, '0, '0, 0, 0, 0, 2, "R2 partial write");
    do_req(0, 4'h0, 4'd2, '0, '0, 32'h11BB_33DD, 1, 0, 0, 2, "R2 merged read");
    drain();

    // R3 / R4 / R10: single flipped bit, scrub and re-read
    do_req(1, 4'hF, 4'd3, 32'hDEAD_BEEF, 39'(1) << 7, '0, 0, 0, 0, 1, "R10 inject single");
    do_req(0, 4'h0, 4'd3, '0, '0, 32'hDEAD_BEEF, 1, 1, 0, 4, "R3 corrected read");
    do_req(0, 4'h0, 4'd3, '0, '0, 32'hDEAD_BEEF, 1, 0, 0, 2, "R4 read after scrub");
    exp_corr = sat(exp_corr + 1);
    // R10: flip on the overall parity bit
    do_req(1, 4'hF, 4'd4, 32'h0F0F_0F0F, 39'(1), '0, 0, 0, 0, 1, "R10 inject parity bit");
    do_req(0, 4'h0, 4'd4, '0, '0, 32'h0F0F_0F0F, 1, 1, 0, 4, "R10 parity bit corrected");
    exp_corr = sat(exp_corr + 1);
    drain();
    chk_cnt("R8 after corrections");

    // R5: double error, no write-back
    do_req(1, 4'hF, 4'd5, 32'h1234_5678, (39'(1) << 3) | (39'(1) << 20), '0, 0, 0, 0, 1, "R10 inject double");
    do_req(0, 4'h0, 4'd5, '0, '0, '0, 0, 0, 1, 2, "R5 uncorrectable read");
    do_req(0, 4'h0, 4'd5, '0, '0, '0, 0, 0, 1, 2, "R5 repeat read");
    exp_uncorr = sat(exp_uncorr + 2);
    // R6: partial write over a double error is aborted
    do_req(1, 4'b0001, 4'd5, 32'h0000_00FF, '0, '0, 0, 0, 1, 2, "R6 aborted partial");
    do_req(0, 4'h0, 4'd5, '0, '0, '0, 0, 0, 1, 2, "R6 still uncorrectable");
    exp_uncorr = sat(exp_uncorr + 2);
    drain();
    chk_cnt("R8 saturation");

    // R2 / R3: partial write over a single error corrects and merges
    do_req(1, 4'hF, 4'd6, 32'hCAFE_F00D, 39'(1) << 30, '0, 0, 0, 0, 1, "R10 inject for rmw");
    do_req(1, 4'b1000, 4'd6, 32'h5500_0000, '0, '0, 0, 1, 0, 2, "R3 partial over single");
    do_req(0, 4'h0, 4'd6, '0, '0, 32'h55FE_F00D, 1, 0, 0, 2, "R2 corrected merge read");
    drain();

    // R9: clear alone
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    exp_corr = 0; exp_uncorr = 0;
    chk_cnt("R9 clear");
    // R9: clear on the same edge as a corrected event
    do_req(1, 4'hF, 4'd7, 32'h7777_0001, 39'(1) << 12, '0, 0, 0, 0, 1, "R10 inject for clear");
    do_req(0, 4'h0, 4'd7, '0, '0, 32'h7777_0001, 1, 1, 0, 4, "R9 read during clear");
    cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    drain();
    chk_cnt("R9 clear beats event");

    // R7 / R1: back-to-back full writes
    do_req(1, 4'hF, 4'd8, 32'h0101_0101, '0, '0, 0, 0, 0, 1, "R7 back to back 1");
    do_req(1, 4'hF, 4'd9, 32'h0202_0202, '0, '0, 0, 0, 0, 1, "R7 back to back 2");
    do_req(0, 4'h0, 4'd9, '0, '0, 32'h0202_0202, 1, 0, 0, 2, "R1 read back to back");
    drain();

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      summary();
    end
  end

endmodule